// File: doc/BRIEF.md
# Ten-bit up/down timer with byte-wide register access

This block is a 10-bit counter that runs up to a programmable top value, turns, runs down to zero and turns again. Software reaches it over an 8-bit register bus. The counter, the top value and compare register A are each 10 bits wide. Their two upper bits travel through a single shared 2-bit staging register. To write a full value, software first sets the staging bits and then writes the low byte, which commits both parts at once. To read a full value, software reads the low byte first. That access copies the register's upper bits into the staging register, where a second read picks them up.

A counter write does not take effect at once. It passes through a short pipeline of `WR_DELAY` clock edges before it reaches the counter, and the counter always restarts in the upward direction. While the counter runs and equals compare register A, the block raises a one-cycle match pulse and sets a sticky flag that software clears by writing 1. A control bit selects a narrow mode. In that mode every low-byte write loads zeros into bits 9:8, and the counter uses only the low 8 bits of the top value.

Top module: `tmr10_bytebus`

## Requirements
- R1: After reset, every register reads zero: the counter, the staging register, compare register A, the top value, the control register and the flag. The counter direction starts as up.
- R2: The staging register sits at address 0x25. A read returns bits 1:0 in rdata[1:0], and rdata[7:2] always reads zero. A write stores only wdata[1:0], and writes to bits 7:2 have no effect.
- R3: The low-byte addresses are counter 0x2E, compare A 0x2D and top 0x2B. A write to one of them commits {staging[1:0], wdata} as the 10-bit value. When control bit 1 (narrow mode) is set, bits 9:8 are committed as zero and the top value is used as top[7:0].
- R4: A read of a low-byte address returns bits 7:0 of that register in the same cycle. The same access copies its bits 9:8 into the single shared staging register.
- R5: A counter write is loaded WR_DELAY clock edges after the edge that accepts it (default 2). Until then, reads return the old count.
- R6: When a counter write is loaded, the direction becomes up, whatever it was before.
- R7: While control bit 0 (run) at address 0x30 is set, the counter steps once per clock. It counts up until it equals top, then down until it reaches zero, then up again. Each turning value lasts exactly one cycle. With top = 0 it stays at zero.
- R8: While run is clear, the counter holds its value, apart from a pending write load.
- R9: In each cycle where run is set and the counter equals compare A, match_o is high during the following cycle and the flag is set at the same edge.
- R10: The flag reads as rdata[0] at address 0x31, with bits 7:1 reading zero. Writing wdata[0] = 1 clears it, unless a match sets it on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; staging side effects happen at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| match_o | output | 1 | One-cycle pulse after the counter equals compare A while running |

## Verification
The counter is checked in several runs. One run starts from zero with an upward direction and shows both turning points each held for a single cycle. Another starts from a value loaded while the counter was heading down, which tells a correct forced-up restart apart from a kept direction. Full 10-bit values are written and read back through the shared staging register, with the staging bits deliberately rewritten in between, to show that a low-byte read really refreshes them. Back-to-back reads after a counter write separate the delayed load from an immediate one. A repeated write in narrow mode shows that stale staging bits are discarded. Match pulses are counted over a known run, and the flag is cleared while the counter is stopped.

// File: rtl/tmr10_pkg.sv
`timescale 1ns/1ps
package tmr10_pkg;
  localparam int unsigned CNT_W = 10;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned HI_W  = CNT_W - BUS_W;

  localparam logic [BUS_W-1:0] A_HI   = 8'h25;
  localparam logic [BUS_W-1:0] A_TOP  = 8'h2B;
  localparam logic [BUS_W-1:0] A_OCRA = 8'h2D;
  localparam logic [BUS_W-1:0] A_CNT  = 8'h2E;
  localparam logic [BUS_W-1:0] A_CTRL = 8'h30;
  localparam logic [BUS_W-1:0] A_FLAG = 8'h31;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [BUS_W-1:0] byte_t;

  typedef struct packed {
    logic narrow;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr10_regs.sv
`timescale 1ns/1ps
module tmr10_regs
  import tmr10_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t addr,
  input  logic  wr,
  input  logic  rd,
  input  byte_t wdata,
  output byte_t rdata,
  input  cnt_t  cnt,
  input  logic  match_set,
  output logic  cnt_wr,
  output cnt_t  cnt_wval,
  output cnt_t  ocra,
  output cnt_t  top_eff,
  output logic  run,
  output logic  flag
);
  localparam int unsigned PAD_W = BUS_W - HI_W;

  logic [HI_W-1:0] hi_q, hi_d;
  cnt_t  ocra_q, ocra_d;
  cnt_t  top_q, top_d;
  ctrl_t ctrl_q, ctrl_d;
  logic  flag_q, flag_d;

  logic wr_hi, wr_top, wr_ocra, wr_cnt, wr_ctrl, wr_flag;
  logic rd_top, rd_ocra, rd_cnt;
  cnt_t wide_val;

  always_comb begin
    wr_hi   = wr && (addr == A_HI);
    wr_top  = wr && (addr == A_TOP);
    wr_ocra = wr && (addr == A_OCRA);
    wr_cnt  = wr && (addr == A_CNT);
    wr_ctrl = wr && (addr == A_CTRL);
    wr_flag = wr && (addr == A_FLAG);
    rd_top  = rd && (addr == A_TOP);
    rd_ocra = rd && (addr == A_OCRA);
    rd_cnt  = rd && (addr == A_CNT);
    wide_val = ctrl_q.narrow ? {{HI_W{1'b0}}, wdata} : {hi_q, wdata};
  end

  // next-state logic
  always_comb begin
    hi_d = hi_q;
    if (wr_hi)        hi_d = wdata[HI_W-1:0];
    else if (rd_cnt)  hi_d = cnt[CNT_W-1:BUS_W];
    else if (rd_ocra) hi_d = ocra_q[CNT_W-1:BUS_W];
    else if (rd_top)  hi_d = top_q[CNT_W-1:BUS_W];

    ocra_d = wr_ocra ? wide_val : ocra_q;
    top_d  = wr_top  ? wide_val : top_q;
    ctrl_d = wr_ctrl ? ctrl_t'(wdata[1:0]) : ctrl_q;

    flag_d = flag_q;
    if (match_set)               flag_d = 1'b1;
    else if (wr_flag && wdata[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      ocra_q <= '0;
      top_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      ocra_q <= ocra_d;
      top_q  <= top_d;
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        A_HI:   rdata = {{PAD_W{1'b0}}, hi_q};
        A_TOP:  rdata = top_q[BUS_W-1:0];
        A_OCRA: rdata = ocra_q[BUS_W-1:0];
        A_CNT:  rdata = cnt[BUS_W-1:0];
        A_CTRL: rdata = {{(BUS_W-2){1'b0}}, ctrl_q};
        A_FLAG: rdata = {{(BUS_W-1){1'b0}}, flag_q};
        default: rdata = '0;
      endcase
    end
  end

  assign cnt_wr   = wr_cnt;
  assign cnt_wval = wide_val;
  assign ocra     = ocra_q;
  assign top_eff  = ctrl_q.narrow ? {{HI_W{1'b0}}, top_q[BUS_W-1:0]} : top_q;
  assign run      = ctrl_q.run;
  assign flag     = flag_q;
endmodule

// File: rtl/tmr10_wrpipe.sv
`timescale 1ns/1ps
module tmr10_wrpipe #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  localparam int unsigned STAGES = (DEPTH > 1) ? DEPTH - 1 : 1;

  generate
    if (DEPTH <= 1) begin : g_direct
      assign out_vld = in_vld;
      assign out_dat = in_dat;
    end else begin : g_pipe
      logic         vld_q [STAGES];
      logic [W-1:0] dat_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic         vld_d;
        logic [W-1:0] dat_d;
        always_comb begin
          if (s == 0) begin
            vld_d = in_vld;
            dat_d = in_dat;
          end else begin
            vld_d = vld_q[(s == 0) ? 0 : s-1];
            dat_d = dat_q[(s == 0) ? 0 : s-1];
          end
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[s] <= 1'b0;
            dat_q[s] <= '0;
          end else begin
            vld_q[s] <= vld_d;
            if (vld_d) dat_q[s] <= dat_d;
          end
        end
      end
      assign out_vld = vld_q[STAGES-1];
      assign out_dat = dat_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tmr10_count.sv
`timescale 1ns/1ps
module tmr10_count
  import tmr10_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  input  cnt_t load_val,
  input  cnt_t top,
  output cnt_t cnt,
  output logic dir_up
);
  localparam cnt_t ONE  = cnt_t'(1);
  localparam cnt_t ZERO = '0;

  cnt_t cnt_q, cnt_d;
  logic up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (load) begin
      cnt_d = load_val;
      up_d  = 1'b1;
    end else if (run) begin
      if (up_q) begin
        if (cnt_q >= top) begin
          up_d  = 1'b0;
          cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == ZERO) begin
          up_d  = 1'b1;
          cnt_d = (top == ZERO) ? ZERO : ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (load || run) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt    = cnt_q;
  assign dir_up = up_q;
endmodule

// File: rtl/tmr10_match.sv
`timescale 1ns/1ps
module tmr10_match
  import tmr10_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cnt_t cnt,
  input  cnt_t ocra,
  output logic hit,
  output logic pulse
);
  logic pulse_q;

  assign hit = run && (cnt == ocra);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= hit;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/tmr10_bytebus.sv
`timescale 1ns/1ps
module tmr10_bytebus
  import tmr10_pkg::*;
#(
  parameter int unsigned WR_DELAY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       match_o
);
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  cnt_t cnt_w, cnt_wval, ocra_w, top_w, load_val;
  logic cnt_wr, run_w, flag_w, hit_w, load_w, dir_w;

  tmr10_regs u_regs (
    .clk(clk), .rst_n(rst_q),
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata), .rdata(bus_rdata),
    .cnt(cnt_w), .match_set(hit_w),
    .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
    .ocra(ocra_w), .top_eff(top_w), .run(run_w), .flag(flag_w)
  );

  tmr10_wrpipe #(.DEPTH(WR_DELAY), .W(CNT_W)) u_pipe (
    .clk(clk), .rst_n(rst_q),
    .in_vld(cnt_wr), .in_dat(cnt_wval),
    .out_vld(load_w), .out_dat(load_val)
  );

  tmr10_count u_count (
    .clk(clk), .rst_n(rst_q),
    .run(run_w), .load(load_w), .load_val(load_val), .top(top_w),
    .cnt(cnt_w), .dir_up(dir_w)
  );

  tmr10_match u_match (
    .clk(clk), .rst_n(rst_q),
    .run(run_w), .cnt(cnt_w), .ocra(ocra_w),
    .hit(hit_w), .pulse(match_o)
  );
endmodule

// File: rtl/tmr10_chk.sv
`timescale 1ns/1ps
module tmr10_chk
  import tmr10_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic       wr,
  input logic       rd,
  input logic       wbit0,
  input logic [7:0] rdata,
  input logic       match_o,
  input cnt_t       cnt,
  input logic       dir_up,
  input logic       run,
  input logic       load,
  input logic       flag,
  input logic       hit
);
  p_hi_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_HI) |-> (rdata[7:2] == 6'b0));

  p_load_forces_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> dir_up);

  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> ((cnt == $past(cnt) + cnt_t'(1)) ||
                        (cnt == $past(cnt) - cnt_t'(1)) || $stable(cnt)));

  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));

  p_pulse_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> flag);

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_FLAG && wbit0 && !hit) |=> !flag);

  p_flag_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_FLAG) |-> (rdata == {7'b0, flag}));
endmodule

bind tmr10_bytebus tmr10_chk u_chk (
  .clk(clk), .rst_n(rst_q), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
  .wbit0(bus_wdata[0]), .rdata(bus_rdata), .match_o(match_o),
  .cnt(cnt_w), .dir_up(dir_w), .run(run_w), .load(load_w),
  .flag(flag_w), .hit(hit_w)
);

// File: tb/test_tmr10_bytebus.sv
`timescale 1ns/1ps
module test_tmr10_bytebus;
  localparam logic [7:0] AD_HI = 8'h25, AD_TOP = 8'h2B, AD_OCR = 8'h2D,
                         AD_CNT = 8'h2E, AD_CTL = 8'h30, AD_FLG = 8'h31;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_wr, bus_rd, match_o;

  int n_checks = 0;
  int n_err    = 0;
  int pulses   = 0;
  bit done     = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  tmr10_bytebus i_tmr10_bytebus (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_o(match_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data and compare mid-cycle
  always @(negedge clk) begin
    if (rst_n && match_o) pulses++;
    if (rst_n && bus_rd) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'(bus_rdata), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic op(input logic [7:0] a, input logic w, input logic r, input logic [7:0] d);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    op(a, 1'b1, 1'b0, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    op(a, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset values
    rd(AD_CNT, 8'h00, "R1 counter reset");
    rd(AD_HI,  8'h00, "R1 staging reset");
    rd(AD_OCR, 8'h00, "R1 compare reset");
    rd(AD_TOP, 8'h00, "R1 top reset");
    rd(AD_CTL, 8'h00, "R1 control reset");
    rd(AD_FLG, 8'h00, "R1 flag reset");

    // R2 staging register: upper bits ignored
    wr(AD_HI, 8'hFE);
    rd(AD_HI, 8'h02, "R2 staging upper bits dropped");

    // R3/R4 compare A full value through shared staging
    wr(AD_OCR, 8'h34);                       // commits 0x234
    wr(AD_HI, 8'h01);
    rd(AD_OCR, 8'h34, "R4 compare low byte");
    rd(AD_HI,  8'h02, "R4 compare high bits copied");
    wr(AD_HI, 8'h01);
    wr(AD_TOP, 8'h10);                       // top 0x110
    wr(AD_HI, 8'h03);
    rd(AD_TOP, 8'h10, "R3 top low byte");
    rd(AD_HI,  8'h01, "R3 top high bits shared staging");

    // set working values: top = 3, compare = 2
    wr(AD_HI, 8'h00);
    wr(AD_TOP, 8'h03);
    wr(AD_OCR, 8'h02);

    // R5 delayed counter load
    wr(AD_HI, 8'h01);
    wr(AD_CNT, 8'h23);
    rd(AD_CNT, 8'h00, "R5 old count before load");
    rd(AD_CNT, 8'h23, "R5 new count after load");
    rd(AD_HI,  8'h01, "R5 loaded high bits");
    wr(AD_HI, 8'h00);
    wr(AD_CNT, 8'h00);
    rd(AD_CNT, 8'h23, "R5 second write still pending");
    rd(AD_CNT, 8'h00, "R5 second write loaded");
    rd(AD_CNT, 8'h00, "R8 stopped counter holds");
    check("R9 no pulse while stopped", pulses, 0);

    // R7 counting up to top and back down, R9 match pulses
    wr(AD_CTL, 8'h01);
    rd(AD_CNT, 8'h00, "R7 run step 0");
    rd(AD_CNT, 8'h01, "R7 run step 1");
    rd(AD_CNT, 8'h02, "R7 run step 2");
    rd(AD_CNT, 8'h03, "R7 run top value");
    rd(AD_CNT, 8'h02, "R7 run turned down");
    wr(AD_CTL, 8'h00);                       // counter 1 -> 0, heading down
    op(8'h00, 1'b0, 1'b0, 8'h00);
    check("R9 match pulse count", pulses, 2);
    rd(AD_CNT, 8'h00, "R8 held after stop");

    // R10 flag read and clear
    rd(AD_FLG, 8'h01, "R10 flag set by match");
    wr(AD_FLG, 8'h01);
    rd(AD_FLG, 8'h00, "R10 flag cleared");

    // R6 write while heading down restarts upward; R7 bottom bounce
    wr(AD_CNT, 8'h01);
    wr(AD_CTL, 8'h01);
    rd(AD_CNT, 8'h01, "R6 loaded value");
    rd(AD_CNT, 8'h02, "R6 counts up after load");
    rd(AD_CNT, 8'h03, "R7 top again");
    rd(AD_CNT, 8'h02, "R7 down 2");
    rd(AD_CNT, 8'h01, "R7 down 1");
    rd(AD_CNT, 8'h00, "R7 bottom value");
    rd(AD_CNT, 8'h01, "R7 turned up at zero");
    rd(AD_CNT, 8'h02, "R7 up again");

    // R3 narrow mode ignores staging bits
    wr(AD_CTL, 8'h02);
    wr(AD_HI, 8'h03);
    wr(AD_OCR, 8'h55);
    rd(AD_OCR, 8'h55, "R3 narrow compare low byte");
    rd(AD_HI,  8'h00, "R3 narrow high bits zero");

    op(8'h00, 1'b0, 1'b0, 8'h00);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule